// File: doc/BRIEF.md
# Mandelbrot Escape Iteration Engine

This block takes one point c of the complex plane and repeatedly applies z ← z² + c, starting from z = c. It reports how many update steps ran before the squared magnitude of z went above 4.0, or reports that it reached the iteration ceiling. Both parts of the point are signed Q4.28 fixed-point words: 32 bits each, with 4 integer bits including the sign and 28 fraction bits. All arithmetic uses plain integer multiply and add.

A run is triggered by a low-to-high transition of a level input called `go`. The transition is found by comparing `go` with a copy of itself registered one clock earlier. On the clock where the transition is seen, the working value, the captured point, the counter and the done flag all take their start values. Iteration then proceeds from the following clock. Each iteration takes three clocks: square, test, update.

When a run ends, the controller returns to idle. The count and the done flag then hold until the next transition of `go`. If `go` drops while a run is still going, the run is dropped and done stays low.

Top module: `mandel_escape`

## Requirements
- R1: While reset is asserted and after it is released with `go` low, `done` is 0 and `iter_count` is 0.
- R2: A run starts only on a clock where `go` is 1 and was 0 on the previous clock. After that clock edge, `done` is 0 and `iter_count` is 0. Holding `go` high does not start another run.
- R3: The point is captured on the starting clock. Changes on `pt_re`/`pt_im` during a run do not affect its result.
- R4: Each iteration takes three clocks, in the order square, test, update. Number the starting clock edge 1. A run that escapes after n updates raises `done` after edge 3n+3. A run that reaches the ceiling raises `done` after edge 766.
- R5: The escape test is re² + im² > 4.0. It is evaluated on the exact full-width products of the current z, in Q4.28 units, so the bound is 4·2^56 on the product scale.
- R6: The update step sets z to (floor(re²/2^28) − floor(im²/2^28) + c_re, floor(2·re·im/2^28) + c_im). Each part is kept modulo 2^32 as a two's-complement word.
- R7: A run that has not escaped stops with `done` = 1 when `iter_count` reaches 255.
- R8: Once `done` is 1, it and `iter_count` hold until the next start, even if `go` falls.
- R9: If `go` falls while a run is going, the run is abandoned and `done` stays 0.
- R10: `iter_count` counts completed update steps. Between clocks it only steps by +1 or returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously inside the block |
| go | input | 1 | Level input; its rising transition starts a run |
| pt_re | input | 32 | Real part of c, signed Q4.28 |
| pt_im | input | 32 | Imaginary part of c, signed Q4.28 |
| iter_count | output | 8 | Number of completed update steps |
| done | output | 1 | High from the end of a run until the next start |

## Verification
A wrong phase in the controller shows up as `done` rising on the wrong clock. The bench compares the exact edge count against 3n+3 for every run, so a slip of even one cycle is reported at the end of that run. A wrong product slice or a wrong escape bound changes the trajectory of z, and the final count drifts for points close to the boundary. For that reason the bench sweeps a full grid of the plane in quarter steps and compares every run against its own integer model. A broken start or abort path appears as `done` staying high, or rising after `go` has dropped. These are checked in the cycles straight after the stimulus.

// File: rtl/mb_pkg.sv
`timescale 1ns/1ps
package mb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SQR  = 2'd1,
    ST_CMP  = 2'd2,
    ST_ADD  = 2'd3
  } mb_state_e;
endpackage

// File: rtl/mb_rst_sync.sv
`timescale 1ns/1ps
module mb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] stage;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end
  assign rst_s = stage[1];
endmodule

// File: rtl/mb_edge_det.sv
`timescale 1ns/1ps
module mb_edge_det (
  input  logic clk,
  input  logic rst_s,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end
  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/mb_datapath.sv
`timescale 1ns/1ps
module mb_datapath #(
  parameter int W    = 32,
  parameter int FRAC = 28
) (
  input  logic         clk,
  input  logic         rst_s,
  input  logic         load,
  input  logic         sq_en,
  input  logic         add_en,
  input  logic [W-1:0] pt_re,
  input  logic [W-1:0] pt_im,
  output logic         esc
);
  localparam int PW = 2 * W;
  localparam logic [PW:0] BOUND = (PW+1)'(4) << (2 * FRAC);

  logic signed [W-1:0]  z_re, z_im, c_re, c_im;
  logic signed [W-1:0]  z_re_n, z_im_n, c_re_n, c_im_n;
  logic signed [PW-1:0] p_rr, p_ii, p_ri;
  logic signed [PW-1:0] p_rr_n, p_ii_n, p_ri_n;
  logic signed [PW-1:0] m_rr, m_ii, m_ri;
  logic [PW:0]          mag;
  logic [W-1:0]         t_rr, t_ii, t_x2;

  function automatic logic signed [PW-1:0] widen(input logic [W-1:0] v);
    return $signed({{W{v[W-1]}}, v});
  endfunction

  always_comb begin
    m_rr = widen(z_re) * widen(z_re);
    m_ii = widen(z_im) * widen(z_im);
    m_ri = widen(z_re) * widen(z_im);
    mag  = {1'b0, p_rr} + {1'b0, p_ii};
    esc  = mag > BOUND;
    t_rr = p_rr[FRAC+W-1:FRAC];
    t_ii = p_ii[FRAC+W-1:FRAC];
    t_x2 = p_ri[FRAC+W-2:FRAC-1];
  end

  always_comb begin
    z_re_n = z_re;  z_im_n = z_im;
    c_re_n = c_re;  c_im_n = c_im;
    p_rr_n = p_rr;  p_ii_n = p_ii;  p_ri_n = p_ri;
    if (load) begin
      z_re_n = pt_re;  z_im_n = pt_im;
      c_re_n = pt_re;  c_im_n = pt_im;
      p_rr_n = '0;     p_ii_n = '0;   p_ri_n = '0;
    end else begin
      if (sq_en) begin
        p_rr_n = m_rr;  p_ii_n = m_ii;  p_ri_n = m_ri;
      end
      if (add_en) begin
        z_re_n = t_rr - t_ii + c_re;
        z_im_n = t_x2 + c_im;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      z_re <= '0;  z_im <= '0;  c_re <= '0;  c_im <= '0;
      p_rr <= '0;  p_ii <= '0;  p_ri <= '0;
    end else begin
      z_re <= z_re_n;  z_im <= z_im_n;
      c_re <= c_re_n;  c_im <= c_im_n;
      p_rr <= p_rr_n;  p_ii <= p_ii_n;  p_ri <= p_ri_n;
    end
  end
endmodule

// File: rtl/mb_ctrl.sv
`timescale 1ns/1ps
module mb_ctrl
  import mb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_s,
  input  logic          rise,
  input  logic          lvl,
  input  logic          esc,
  output logic          sq_en,
  output logic          add_en,
  output logic [CW-1:0] cnt,
  output logic          fin,
  output mb_state_e     st
);
  localparam logic [CW-1:0] CEIL = '1;

  mb_state_e     st_n;
  logic [CW-1:0] cnt_n, cnt_inc;
  logic          fin_n, abort;

  assign abort   = (st != ST_IDLE) && !lvl;
  assign sq_en   = (st == ST_SQR) && lvl;
  assign add_en  = (st == ST_ADD) && lvl;
  assign cnt_inc = cnt + 1'b1;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    fin_n = fin;
    if (rise) begin
      st_n  = ST_SQR;
      cnt_n = '0;
      fin_n = 1'b0;
    end else if (abort) begin
      st_n  = ST_IDLE;
      fin_n = 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: st_n = ST_IDLE;
        ST_SQR:  st_n = ST_CMP;
        ST_CMP: begin
          if (esc) begin
            st_n  = ST_IDLE;
            fin_n = 1'b1;
          end else begin
            st_n  = ST_ADD;
          end
        end
        ST_ADD: begin
          cnt_n = cnt_inc;
          if (cnt_inc == CEIL) begin
            st_n  = ST_IDLE;
            fin_n = 1'b1;
          end else begin
            st_n  = ST_SQR;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st  <= ST_IDLE;
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      fin <= fin_n;
    end
  end
endmodule

// File: rtl/mandel_escape.sv
`timescale 1ns/1ps
module mandel_escape
  import mb_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 28,
  parameter int CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [W-1:0]  pt_re,
  input  logic [W-1:0]  pt_im,
  output logic [CW-1:0] iter_count,
  output logic          done
);
  logic      rst_s, rise, esc, sq_en, add_en;
  mb_state_e st;

  mb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  mb_edge_det u_edge (.clk(clk), .rst_s(rst_s), .lvl(go), .rise(rise));

  mb_datapath #(.W(W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rst_s(rst_s), .load(rise), .sq_en(sq_en), .add_en(add_en),
    .pt_re(pt_re), .pt_im(pt_im), .esc(esc)
  );

  mb_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_s(rst_s), .rise(rise), .lvl(go), .esc(esc),
    .sq_en(sq_en), .add_en(add_en), .cnt(iter_count), .fin(done), .st(st)
  );
endmodule

// File: rtl/mandel_escape_chk.sv
`timescale 1ns/1ps
module mandel_escape_chk
  import mb_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_s,
  input logic          go,
  input logic          rise,
  input logic [CW-1:0] iter_count,
  input logic          done,
  input mb_state_e     st
);
  // R2: a start clears done and the count
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_s)
    rise |=> (!done && iter_count == '0));

  // R8: a finished result holds until the next start
  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (done && !rise) |=> (done && $stable(iter_count)));

  // R9: done never rises after a clock with go low
  assert_no_done_after_drop_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (!go && !done) |=> !done);

  // R4: completion comes only out of the test or update phase
  assert_done_from_phase_R4: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(done) |-> ($past(st) == ST_CMP || $past(st) == ST_ADD));

  // R10: the count steps by one or returns to zero
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (iter_count != $past(iter_count)) |->
      (iter_count == $past(iter_count) + 1'b1 || iter_count == '0));
endmodule

bind mandel_escape mandel_escape_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_s(rst_s), .go(go), .rise(rise),
  .iter_count(iter_count), .done(done), .st(st)
);

// File: tb/mandel_escape_test.sv
`timescale 1ns/1ps
module mandel_escape_test;
  logic        clk, rst_n, go;
  logic [31:0] pt_re, pt_im;
  logic [7:0]  iter_count;
  logic        done;
  int checks, fails;

  mandel_escape uut (
    .clk(clk), .rst_n(rst_n), .go(go), .pt_re(pt_re), .pt_im(pt_im),
    .iter_count(iter_count), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // integer model of the requirements: returns update count, flags escape
  task automatic model(input logic [31:0] cr, input logic [31:0] ci,
                       output int n, output bit escaped);
    logic [31:0]  zr, zi;
    longint       rr, ii, ri;
    logic [64:0]  sum;
    logic [64:0]  lim;
    zr = cr; zi = ci; n = 0; escaped = 0;
    lim = 65'd4 << 56;
    while (1) begin
      rr = longint'($signed(zr)) * longint'($signed(zr));
      ii = longint'($signed(zi)) * longint'($signed(zi));
      ri = longint'($signed(zr)) * longint'($signed(zi));
      sum = {1'b0, rr} + {1'b0, ii};
      if (sum > lim) begin escaped = 1; break; end
      zr = 32'(rr >>> 28) - 32'(ii >>> 28) + cr;
      zi = 32'(ri >>> 27) + ci;
      n++;
      if (n == 255) break;
    end
  endtask

  // start a run with go low for one clock first; scramble the inputs after start
  task automatic run(input logic [31:0] cr, input logic [31:0] ci, output int cyc);
    @(negedge clk); go = 1'b0;
    @(negedge clk); pt_re = cr; pt_im = ci; go = 1'b1;
    cyc = 0;
    while (cyc < 2000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      pt_re = ~cr ^ 32'(cyc * 7919); pt_im = cr + 32'(cyc);  // R3 stimulus
      if (done) break;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, cyc, exp_cyc;
    bit esc;
    logic [7:0] held;
    checks = 0; fails = 0;
    rst_n = 1'b0; go = 1'b0; pt_re = '0; pt_im = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && iter_count == 8'd0, "R1 reset state", iter_count, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && iter_count == 8'd0, "R1 after release", done, 0);

    // grid sweep in quarter steps: re -2.0..0.5, im -1.25..1.25
    for (int i = 0; i < 11; i++) begin
      for (int j = 0; j < 11; j++) begin
        logic [31:0] cr, ci;
        cr = 32'((i - 8) * (1 << 26));
        ci = 32'((j - 5) * (1 << 26));
        model(cr, ci, n, esc);
        run(cr, ci, cyc);
        exp_cyc = esc ? 3 * n + 3 : 766;
        chk(done == 1'b1, "R7 R5 done at end of run", done, 1);
        chk(iter_count == 8'(n), "R3 R5 R6 count vs model", iter_count, n);
        chk(cyc == exp_cyc, "R4 completion edge", cyc, exp_cyc);
      end
    end

    // R8: hold with go high, then with go low
    held = iter_count;
    repeat (10) @(negedge clk);
    chk(done && iter_count == held, "R8 R2 hold with go high", iter_count, held);
    go = 1'b0;
    repeat (10) @(negedge clk);
    chk(done && iter_count == held, "R8 hold with go low", iter_count, held);

    // R2: next start clears outputs after the starting edge
    pt_re = 32'(-(2 << 28)); pt_im = 32'(1 << 28);
    go = 1'b1;
    @(negedge clk);
    chk(!done && iter_count == 0, "R2 start clears", {done, iter_count}, 0);

    // R9: abandon a long run (c = 0 never escapes)
    @(negedge clk); go = 1'b0;
    @(negedge clk); pt_re = '0; pt_im = '0; go = 1'b1;
    repeat (10) @(negedge clk);
    go = 1'b0;
    begin
      bit seen;
      seen = 0;
      for (int k = 0; k < 800; k++) begin
        @(negedge clk);
        if (done) seen = 1;
      end
      chk(!seen, "R9 no done after abort", seen, 0);
    end

    // recovery run after abort; -0.75+0.25i escapes eventually
    model(32'(-(3 << 26)), 32'(1 << 26), n, esc);
    run(32'(-(3 << 26)), 32'(1 << 26), cyc);
    chk(iter_count == 8'(n) && done, "R9 run after abort", iter_count, n);

    // R7: exact ceiling with point -1+0i (periodic orbit)
    run(32'(-(1 << 28)), 32'd0, cyc);
    chk(iter_count == 8'd255, "R7 ceiling count", iter_count, 255);
    chk(cyc == 766, "R7 R4 ceiling latency", cyc, 766);

    // R5: point exactly on bound 2+0i: |z|^2 == 4 does not escape first test
    run(32'(2 << 28), 32'd0, cyc);
    model(32'(2 << 28), 32'd0, n, esc);
    chk(iter_count == 8'(n) && iter_count == 8'd1, "R5 bound equality", iter_count, 1);

    // R10 sanity: minimal escape 2.25+0i has zero updates
    run(32'(9 << 26), 32'd0, cyc);
    chk(iter_count == 8'd0 && cyc == 3, "R10 zero updates", cyc, 3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule